// File: doc/BRIEF.md
# Fractional Rate Clock Generator

This block derives a slower clock from its source clock by a programmable ratio. The ratio has two parts: a numerator X and a denominator Y, each eight bits wide by default. A pulse distributor raises a one-cycle enable exactly X times in every Y source cycles and spaces these enables as evenly as integer timing allows. Each enable flips an output flip-flop. The squared output clock therefore runs at source × (X/Y) / 2, and every one of its edges falls on a source-clock edge.

Software sets the ratio by writing one 32-bit configuration word through a simple write strobe, and it can read the word back at any time. A zero in either field stops the output and holds it low. Every write restarts the distributor from a clean phase, so the first enable after a write comes after a fixed, predictable number of cycles. The one-cycle enable is also brought out on its own port, for logic that prefers a clock enable to a derived clock.

Top module: `frac_clk_gen`

## Requirements
- R1: After a synchronous active-low reset, the numerator and denominator are both 0, the read word is 0, and `mclk_tick` and `mclk_out` are both 0.
- R2: A write with `cfg_we` high stores bits 7:0 of `cfg_wdata` as the denominator Y and bits 15:8 as the numerator X. From the next cycle, `cfg_rdata` returns X in bits 15:8, Y in bits 7:0 and 0 in bits 31:16. Software keeps bits 31:16 at 0 when it writes.
- R3: While X or Y is 0, `mclk_tick` stays 0. From the second cycle after the halting write, `mclk_out` stays 0.
- R4: With 0 < X ≤ Y, every run of Y consecutive cycles after a write holds exactly X cycles with `mclk_tick` high.
- R5: With 0 < X ≤ Y, the gap between two consecutive ticks is either floor(Y/X) or ceil(Y/X) cycles. This keeps each edge within one source cycle of its ideal position.
- R6: `mclk_out` inverts at the clock edge that follows each cycle in which `mclk_tick` is high, and keeps its value otherwise.
- R7: When X divides Y evenly, every gap between ticks equals Y/X, so the output has no jitter.
- R8: A write restarts the phase. `mclk_tick` is 0 in the cycle after the write edge, and the n-th cycle after that edge is a tick exactly when floor(n·X/Y) > floor((n−1)·X/Y). The first tick therefore comes ceil(Y/X) cycles after the write.
- R9: With X = Y ≠ 0, `mclk_tick` is high in every cycle from the first cycle after the write onward, so `mclk_out` runs at half the source rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: X in 15:8, Y in 7:0 |
| cfg_rdata | output | 32 | Read-back of the configuration word |
| mclk_tick | output | 1 | One-cycle enable, X per Y source cycles |
| mclk_out | output | 1 | Squared output clock, toggled by each tick |

## Verification
The bench builds the block with its default 8-bit fields and 32-bit word, so the full field range is available, up to the extreme ratios 255/255 and 200/255. With these widths it can test an uneven ratio (7/17), several evenly dividing ratios (2/4, 3/9, 1/6), the full-rate case X = Y, and a halt caused by a zero in each field in turn. After each write it predicts every tick from the floor formula. It also counts ticks over two windows of Y cycles and measures every gap between ticks against the one-cycle bound.

// File: rtl/frg_pkg.sv
// frg_pkg: shared constants and helpers for the fractional rate clock generator.
// Assumes nothing beyond the widths given to the modules that import it.
package frg_pkg;
    localparam int FRG_DEF_FRAC_W = 8;
    localparam int FRG_DEF_REG_W  = 32;

    // True when a ratio field pair must stop the output clock.
    function automatic logic frg_is_halted(input logic num_zero, input logic den_zero);
        return num_zero | den_zero;
    endfunction
endpackage

// File: rtl/frg_cfg_reg.sv
// frg_cfg_reg: holds the numerator and denominator fields of the ratio word.
// Denominator sits in the low field, numerator directly above it; any bits
// above both fields are reserved, read back as zero and expected zero on write.
// Assumes REG_W >= 2*FRAC_W.
module frg_cfg_reg #(
    parameter int FRAC_W = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [FRAC_W-1:0] num,
    output logic [FRAC_W-1:0] den,
    output logic [REG_W-1:0]  rd_data
);
    localparam int FIELDS_W = 2 * FRAC_W;

    logic [FRAC_W-1:0] num_q;
    logic [FRAC_W-1:0] den_q;

    // Capture both fields on a write strobe; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= '0;
            den_q <= '0;
        end else if (wr_en) begin
            num_q <= wr_data[FIELDS_W-1:FRAC_W];
            den_q <= wr_data[FRAC_W-1:0];
        end
    end

    assign num = num_q;
    assign den = den_q;

    // Pad the read word with zeros above the fields when the word is wider.
    generate
        if (REG_W > FIELDS_W) begin : g_pad
            assign rd_data = {{(REG_W-FIELDS_W){1'b0}}, num_q, den_q};

            // Reserved bits must be written as zero (R2 usage rule).
            p_rsv_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |-> (wr_data[REG_W-1:FIELDS_W] == '0));
        end else begin : g_nopad
            assign rd_data = {num_q, den_q};
        end
    endgenerate

    // A written word reads back on the next cycle (R2).
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[FIELDS_W-1:0] == $past(wr_data[FIELDS_W-1:0])));
endmodule

// File: rtl/frg_pulse_dist.sv
// frg_pulse_dist: accumulator-based pulse distributor. It adds the numerator
// each cycle; once the sum reaches the denominator, it takes the denominator
// off and raises a registered one-cycle pulse. This yields num pulses per den
// cycles, spread evenly. A restart or a zero field clears the accumulator.
// Assumes num <= den for the bounded, evenly spread behaviour.
module frg_pulse_dist
    import frg_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [FRAC_W-1:0] num,
    input  logic [FRAC_W-1:0] den,
    output logic              pulse
);
    localparam int ACC_W = FRAC_W + 1;
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic             halted;
    logic             wrap;

    // Next sum and the wrap decision for this cycle.
    always_comb begin
        halted = frg_is_halted(num == '0, den == '0);
        sum    = SUM_W'(acc_q) + SUM_W'(num);
        wrap   = (sum >= SUM_W'(den));
    end

    // Advance the accumulator and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || halted) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else if (wrap) begin
            acc_q <= ACC_W'(sum - SUM_W'(den));
            pulse <= 1'b1;
        end else begin
            acc_q <= ACC_W'(sum);
            pulse <= 1'b0;
        end
    end

    // A zero field yields no pulse (R3).
    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !pulse);

    // A restart clears the phase (R8).
    p_restart_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (acc_q == '0 && !pulse));

    // The accumulator stays below the denominator for a legal ratio (R4, R5).
    p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !halted && num <= den && acc_q < ACC_W'(den))
        |=> (acc_q < ACC_W'($past(den))));

    // An equal ratio pulses every cycle (R9).
    p_full_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !halted && num == den) |=> pulse);
endmodule

// File: rtl/frg_toggle.sv
// frg_toggle: divide-by-two stage. Each input pulse inverts the output flop,
// which squares the output clock. A halt forces the flop low.
// Assumes pulse is a registered signal in the same clock domain.
module frg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic pulse,
    output logic clk_q
);
    // Flip on a pulse, clear on a halt or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            clk_q <= 1'b0;
        end else if (pulse) begin
            clk_q <= ~clk_q;
        end
    end

    // A pulse flips the output on the next edge (R6).
    p_flip_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && pulse) |=> (clk_q != $past(clk_q)));

    // With no pulse, the output holds (R6).
    p_hold_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !pulse) |=> $stable(clk_q));

    // A halt drives the output low (R3).
    p_halt_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !clk_q);
endmodule

// File: rtl/frac_clk_gen.sv
// frac_clk_gen: top of the fractional rate clock generator. It takes a
// configuration word holding the numerator and denominator, emits num ticks
// per den source cycles and a squared clock at source*(num/den)/2.
// Assumes num <= den; a zero in either field stops the output.
module frac_clk_gen
    import frg_pkg::*;
#(
    parameter int FRAC_W = FRG_DEF_FRAC_W,
    parameter int REG_W  = FRG_DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             mclk_tick,
    output logic             mclk_out
);
    logic [FRAC_W-1:0] num;
    logic [FRAC_W-1:0] den;
    logic              halted;

    // Stopping condition derived from the stored fields.
    always_comb begin
        halted = frg_is_halted(num == '0, den == '0);
    end

    frg_cfg_reg #(.FRAC_W(FRAC_W), .REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .num     (num),
        .den     (den),
        .rd_data (cfg_rdata)
    );

    frg_pulse_dist #(.FRAC_W(FRAC_W)) u_dist (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .num     (num),
        .den     (den),
        .pulse   (mclk_tick)
    );

    frg_toggle u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halted),
        .pulse (mclk_tick),
        .clk_q (mclk_out)
    );

    // Outputs are quiet in the first cycle after reset (R1).
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mclk_tick && !mclk_out && cfg_rdata == '0));
endmodule

// File: tb/tb_frac_clk_gen.sv
module tb_frac_clk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mclk_tick;
    logic        mclk_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    frac_clk_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mclk_tick (mclk_tick),
        .mclk_out  (mclk_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write a word: one edge with the strobe high, then sample just after it.
    task automatic write_cfg(input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {16'h0000, x, y};
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    function automatic bit exp_tick(input int n, input int x, input int y);
        return ((n * x) / y) != (((n - 1) * x) / y);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "tick after reset", mclk_tick, 0);
        check("R1", "clock after reset", mclk_out, 0);
        check("R1", "read word after reset", cfg_rdata, 0);
    endtask

    task automatic t_regs();
        write_cfg(8'h12, 8'h34);
        check("R2", "read word 12/34", cfg_rdata, 32'h0000_1234);
        write_cfg(8'hA5, 8'hFE);
        check("R2", "numerator field", cfg_rdata[15:8], 8'hA5);
        check("R2", "denominator field", cfg_rdata[7:0], 8'hFE);
        check("R2", "reserved bits read zero", cfg_rdata[31:16], 0);
    endtask

    task automatic t_halt(input logic [7:0] x, input logic [7:0] y);
        write_cfg(x, y);
        check("R3", "tick right after halting write", mclk_tick, 0);
        @(negedge clk);
        for (int n = 2; n < 40; n++) begin
            @(negedge clk);
            check("R3", "halted tick", mclk_tick, 0);
            check("R3", "halted clock", mclk_out, 0);
        end
    endtask

    // Run a legal ratio and check every cycle, the windows and the gaps.
    task automatic t_ratio(input int x, input int y);
        bit prev_tick;
        bit prev_clk;
        int last_tick = -1;
        int win0 = 0;
        int win1 = 0;
        int lo = y / x;
        int hi = (y + x - 1) / x;
        bit seen_first = 1'b0;
        write_cfg(8'(x), 8'(y));
        check("R8", "no tick right after write", mclk_tick, 0);
        prev_tick = mclk_tick;
        prev_clk  = mclk_out;
        for (int n = 1; n <= 2 * y + 4; n++) begin
            @(negedge clk);
            check("R8", $sformatf("tick n=%0d ratio %0d/%0d", n, x, y), mclk_tick, exp_tick(n, x, y));
            check("R6", $sformatf("clock n=%0d", n), mclk_out, prev_clk ^ prev_tick);
            if (x == y) check("R9", "full rate tick", mclk_tick, 1);
            if (mclk_tick) begin
                if (n <= y) win0++;
                else if (n <= 2 * y) win1++;
                if (!seen_first) begin
                    check("R8", "first tick position", n, hi);
                    seen_first = 1'b1;
                end else begin
                    if (lo == hi) check("R7", "even-ratio gap", n - last_tick, lo);
                    else check("R5", "gap within bound",
                               ((n - last_tick) == lo || (n - last_tick) == hi) ? 1 : 0, 1);
                end
                last_tick = n;
            end
            prev_tick = mclk_tick;
            prev_clk  = mclk_out;
        end
        check("R4", "ticks in first window", win0, x);
        check("R4", "ticks in second window", win1, x);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_halt(8'd0, 8'd9);
        t_ratio(7, 17);
        t_ratio(2, 4);
        t_ratio(3, 9);
        t_ratio(1, 6);
        t_halt(8'd3, 8'd0);
        t_ratio(1, 1);
        t_ratio(5, 5);
        t_ratio(255, 255);
        t_ratio(200, 255);
        t_ratio(1, 255);
        t_halt(8'd0, 8'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule